// File: doc/BRIEF.md
# Load/Store Data Formatting Unit

This block shapes the data of a single transfer between a register file and a 64-bit memory port. Each request carries an access size code, a direction (load or store), a register class (integer or vector), a signed flag and a 32-bit-extend flag. It also carries the byte address and, for stores, a 128-bit source value. For a store, the unit places the source bytes on the right byte lanes of the memory word and raises the matching byte enables. For a load, it takes the addressed bytes out of the returned memory word. It then sign- or zero-extends them for integer registers, or zero-fills a 128-bit vector register.

A 16-byte vector transfer needs two memory beats. The low half always goes first, at the base address, and the high half follows at base + 8. The request side uses a valid/ready handshake and takes one request at a time. A one-cycle done pulse marks completion, and an error flag rides on that pulse when the size and flag combination is not allowed. Address generation and alignment checking are left to the surrounding logic, so a request is expected to carry a naturally aligned address.

Top module: `ldst_fmt_unit`

## Requirements
- R1: Size codes 0, 1, 2 and 3 move 1, 2, 4 and 8 bytes. For a naturally aligned address, the beat's byte enables `mem_be` cover exactly that many lanes, starting at lane `addr[2:0]` (bit i of `mem_be` is byte lane i).
- R2: Size code 4 (16 bytes) is legal only with `req_vec`=1. Size codes 5 to 7 are always illegal.
- R3: An integer load with `req_signed`=1 copies the top bit of the loaded value into every higher bit up to bit 63. With `req_signed`=0 those bits are zero. `rdata[127:64]` is zero for integer loads.
- R4: An integer load with both `req_signed` and `req_ext32` set clears `rdata[63:32]` after sign extension. The same pair with size code 3 is illegal. `req_ext32` without `req_signed` has no effect.
- R5: A vector store puts only the low 2^size bytes of `req_wdata` onto the memory lanes. All higher source bytes are ignored, and write lanes outside the access carry zero.
- R6: A vector load writes all 128 bits of `rdata`, with every bit above the accessed bytes set to 0. `req_signed` is ignored for vector transfers.
- R7: A 16-byte access makes exactly two beats, all byte enables set in each. The first beat is at the request address and carries or receives bits 63:0. The second beat is at address + 8 and carries or receives bits 127:64.
- R8: Byte order is little-endian: register byte k maps to memory lane `addr[2:0]`+k, and the lowest address holds the least significant byte.
- R9: After reset, `req_ready`=1 while `mem_valid`, `done`, `err` and `rdata` are 0. `req_ready` stays low from acceptance until the cycle that `done` pulses. `done` pulses for one cycle in the cycle after the last beat's `mem_valid`&`mem_ready`. A new request may be accepted in that same cycle.
- R10: An illegal request raises `err` together with `done` in the cycle after acceptance, and issues no memory beat.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_be` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_size | input | 3 | Access size code, 0 to 4 legal |
| req_signed | input | 1 | Sign-extend integer load result |
| req_ext32 | input | 1 | Clear upper 32 bits after sign extension |
| req_vec | input | 1 | 1 = vector register, 0 = integer |
| req_load | input | 1 | 1 = load, 0 = store |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 128 | Store source register value |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts the beat (load data valid this cycle) |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Byte address of the beat |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Write data, lane-aligned |
| mem_rdata | input | 64 | Read data for the beat |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request was illegal (with done) |
| rdata | output | 128 | Formatted load result, held until the next load |

## Verification
Completion of one request and acceptance of the next can fall in the same cycle. `done` rises exactly when `req_ready` returns, so a request held on `req_valid` during a busy transfer is taken at the edge that ends the done cycle. The bench holds an illegal request waiting behind a legal 8-byte load. At the first done pulse it checks that `err` is clear, `req_ready` is high and `rdata` holds the loaded word. At the very next cycle it checks a second done pulse with `err` set and no memory beat issued.

// File: rtl/ldst_fmt_pkg.sv
package ldst_fmt_pkg;

    localparam int BEAT_W  = 64;
    localparam int LANES   = BEAT_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int VREG_W  = 2 * BEAT_W;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DBL  = 3'd3,
        SZ_QUAD = 3'd4
    } size_e;

    typedef struct packed {
        logic [2:0] size;
        logic       sgn;
        logic       x32;
        logic       vec;
        logic       ld;
    } xfer_ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO,
        ST_HI
    } xfer_state_e;

    // unshifted lane mask for one beat of the given size
    function automatic logic [LANES-1:0] size_lanes(input logic [2:0] size);
        logic [LANES-1:0] m;
        case (size)
            SZ_BYTE: m = LANES'(8'h01);
            SZ_HALF: m = LANES'(8'h03);
            SZ_WORD: m = LANES'(8'h0F);
            default: m = '1;
        endcase
        return m;
    endfunction

    // expand a lane mask into a bit mask over the beat
    function automatic logic [BEAT_W-1:0] lanes_to_bits(input logic [LANES-1:0] m);
        logic [BEAT_W-1:0] b;
        for (int i = 0; i < LANES; i++) begin
            b[i*8 +: 8] = {8{m[i]}};
        end
        return b;
    endfunction

    // address bits that must be zero for a naturally aligned access
    function automatic logic [OFF_W-1:0] align_bits(input logic [2:0] size);
        case (size)
            SZ_BYTE: return OFF_W'(0);
            SZ_HALF: return OFF_W'(1);
            SZ_WORD: return OFF_W'(3);
            default: return OFF_W'(7);
        endcase
    endfunction

    function automatic int size_bytes(input logic [2:0] size);
        case (size)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/ldst_req_check.sv
module ldst_req_check
    import ldst_fmt_pkg::*;
(
    input  xfer_ctl_t ctl,
    output logic      illegal
);
    logic bad_code;
    logic quad_int;
    logic x32_dbl;

    always_comb begin
        bad_code = (ctl.size > SZ_QUAD);
        quad_int = (ctl.size == SZ_QUAD) && !ctl.vec;
        x32_dbl  = !ctl.vec && ctl.sgn && ctl.x32 && (ctl.size == SZ_DBL);
        illegal  = bad_code || quad_int || x32_dbl;
    end
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
    import ldst_fmt_pkg::*;
(
    input  xfer_ctl_t          ctl,
    input  logic [OFF_W-1:0]   off,
    input  logic               hi_beat,
    input  logic [VREG_W-1:0]  src,
    output logic [LANES-1:0]   be,
    output logic [BEAT_W-1:0]  wdata
);
    logic [OFF_W-1:0]  eff_off;
    logic [LANES-1:0]  keep;
    logic [BEAT_W-1:0] half;
    logic [BEAT_W-1:0] trimmed;

    always_comb begin
        eff_off = (ctl.size == SZ_QUAD) ? '0 : off;
        keep    = size_lanes(ctl.size);
        half    = hi_beat ? src[VREG_W-1:BEAT_W] : src[BEAT_W-1:0];
        trimmed = half & lanes_to_bits(keep);
        be      = keep << eff_off;
        wdata   = trimmed << {eff_off, 3'b000};
    end
endmodule

// File: rtl/ldst_load_extend.sv
module ldst_load_extend
    import ldst_fmt_pkg::*;
(
    input  xfer_ctl_t          ctl,
    input  logic [OFF_W-1:0]   off,
    input  logic [BEAT_W-1:0]  beat,
    output logic [BEAT_W-1:0]  value
);
    logic [BEAT_W-1:0] raw;
    logic              sx;

    always_comb begin
        raw = beat >> {off, 3'b000};
        sx  = ctl.sgn && !ctl.vec;
        case (ctl.size)
            SZ_BYTE: value = {{(BEAT_W-8){sx & raw[7]}},   raw[7:0]};
            SZ_HALF: value = {{(BEAT_W-16){sx & raw[15]}}, raw[15:0]};
            SZ_WORD: value = {{(BEAT_W-32){sx & raw[31]}}, raw[31:0]};
            default: value = raw;
        endcase
        if (sx && ctl.x32) begin
            value[BEAT_W-1:32] = '0;
        end
    end
endmodule

// File: rtl/ldst_fmt_unit.sv
module ldst_fmt_unit
    import ldst_fmt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_size,
    input  logic              req_signed,
    input  logic              req_ext32,
    input  logic              req_vec,
    input  logic              req_load,
    input  logic [AW-1:0]     req_addr,
    input  logic [127:0]      req_wdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_be,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic              err,
    output logic [127:0]      rdata
);
    localparam logic [AW-1:0] HI_STEP = AW'(LANES);

    xfer_state_e        state;
    xfer_ctl_t          ctl_in;
    xfer_ctl_t          ctl_q;
    logic [AW-1:0]      addr_q;
    logic [VREG_W-1:0]  wsrc_q;
    logic [BEAT_W-1:0]  lo_q;
    logic [VREG_W-1:0]  rdata_q;
    logic               done_q;
    logic               err_q;
    logic               illegal_in;
    logic               accept;
    logic               hi_beat;
    logic [BEAT_W-1:0]  ext_val;

    assign ctl_in = '{size: req_size, sgn: req_signed, x32: req_ext32,
                      vec: req_vec, ld: req_load};

    ldst_req_check u_check (
        .ctl     (ctl_in),
        .illegal (illegal_in)
    );

    assign hi_beat   = (state == ST_HI);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign mem_valid = (state != ST_IDLE);
    assign mem_we    = !ctl_q.ld;
    assign mem_addr  = hi_beat ? addr_q + HI_STEP : addr_q;

    ldst_store_lanes u_store (
        .ctl     (ctl_q),
        .off     (addr_q[OFF_W-1:0]),
        .hi_beat (hi_beat),
        .src     (wsrc_q),
        .be      (mem_be),
        .wdata   (mem_wdata)
    );

    ldst_load_extend u_load (
        .ctl   (ctl_q),
        .off   (addr_q[OFF_W-1:0]),
        .beat  (mem_rdata),
        .value (ext_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            wsrc_q  <= '0;
            lo_q    <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        ctl_q  <= ctl_in;
                        addr_q <= req_addr;
                        wsrc_q <= req_wdata;
                        if (illegal_in) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            state <= ST_LO;
                        end
                    end
                end
                ST_LO: begin
                    if (mem_ready) begin
                        if (ctl_q.size == SZ_QUAD) begin
                            lo_q  <= mem_rdata;
                            state <= ST_HI;
                        end else begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                            if (ctl_q.ld) begin
                                rdata_q <= {{(VREG_W-BEAT_W){1'b0}}, ext_val};
                            end
                        end
                    end
                end
                ST_HI: begin
                    if (mem_ready) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        if (ctl_q.ld) begin
                            rdata_q <= {mem_rdata, lo_q};
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done  = done_q;
    assign err   = err_q;
    assign rdata = rdata_q;

    logic aligned_beat;
    assign aligned_beat = (mem_addr[OFF_W-1:0] & align_bits(ctl_q.size)) == '0;

    AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_valid);                                          // R9
    AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> $past(mem_valid && mem_ready));                  // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && !mem_valid));                                      // R10
    AST_NO_BEAT_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) |-> $past(!illegal_in));                           // R2
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
            && $stable(mem_be) && $stable(mem_wdata)));                     // R11
    AST_HI_BEAT_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !hi_beat && ctl_q.size == SZ_QUAD)
            |=> (mem_valid && mem_addr == $past(mem_addr) + HI_STEP));       // R7
    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && aligned_beat)
            |-> ($countones(mem_be) == size_bytes(ctl_q.size)));            // R1
endmodule

// File: tb/test_ldst_fmt_unit.sv
module test_ldst_fmt_unit;

    localparam logic [63:0]  MEM_LO = 64'hF1E2D3C4B5A69788;
    localparam logic [63:0]  MEM_HI = 64'h0123456789ABCDEF;
    localparam logic [127:0] SRC    = {64'h1122334455667788, 64'h99AABBCCDDEEFF5A};

    typedef struct packed {
        logic [2:0]   sz;
        logic         sg;
        logic         x3;
        logic         ve;
        logic         ld;
        logic [15:0]  ad;
        logic         er;
        logic [1:0]   nb;
        logic [7:0]   b0;
        logic [7:0]   b1;
        logic [63:0]  w0;
        logic [63:0]  w1;
        logic [127:0] rd;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{3'd0,1'b0,1'b0,1'b0,1'b1,16'h0102,1'b0,2'd1,8'h04,8'h00,64'h0,64'h0,128'h00000000000000A6},
        '{3'd0,1'b1,1'b0,1'b0,1'b1,16'h0102,1'b0,2'd1,8'h04,8'h00,64'h0,64'h0,128'hFFFFFFFFFFFFFFA6},
        '{3'd1,1'b1,1'b0,1'b0,1'b1,16'h0106,1'b0,2'd1,8'hC0,8'h00,64'h0,64'h0,128'hFFFFFFFFFFFFF1E2},
        '{3'd2,1'b1,1'b1,1'b0,1'b1,16'h0104,1'b0,2'd1,8'hF0,8'h00,64'h0,64'h0,128'h00000000F1E2D3C4},
        '{3'd2,1'b1,1'b0,1'b0,1'b1,16'h0104,1'b0,2'd1,8'hF0,8'h00,64'h0,64'h0,128'hFFFFFFFFF1E2D3C4},
        '{3'd3,1'b0,1'b0,1'b0,1'b1,16'h0100,1'b0,2'd1,8'hFF,8'h00,64'h0,64'h0,128'hF1E2D3C4B5A69788},
        '{3'd1,1'b1,1'b0,1'b1,1'b1,16'h0102,1'b0,2'd1,8'h0C,8'h00,64'h0,64'h0,128'h000000000000B5A6},
        '{3'd4,1'b0,1'b0,1'b1,1'b1,16'h0100,1'b0,2'd2,8'hFF,8'hFF,64'h0,64'h0,{MEM_HI,MEM_LO}},
        '{3'd2,1'b1,1'b0,1'b0,1'b1,16'h010C,1'b0,2'd1,8'hF0,8'h00,64'h0,64'h0,128'h0000000001234567},
        '{3'd2,1'b0,1'b1,1'b0,1'b1,16'h0104,1'b0,2'd1,8'hF0,8'h00,64'h0,64'h0,128'h00000000F1E2D3C4},
        '{3'd0,1'b0,1'b0,1'b0,1'b0,16'h0105,1'b0,2'd1,8'h20,8'h00,64'h00005A0000000000,64'h0,128'h0},
        '{3'd1,1'b0,1'b0,1'b0,1'b0,16'h0102,1'b0,2'd1,8'h0C,8'h00,64'h00000000FF5A0000,64'h0,128'h0},
        '{3'd2,1'b0,1'b0,1'b1,1'b0,16'h0104,1'b0,2'd1,8'hF0,8'h00,64'hDDEEFF5A00000000,64'h0,128'h0},
        '{3'd4,1'b0,1'b0,1'b1,1'b0,16'h0200,1'b0,2'd2,8'hFF,8'hFF,64'h99AABBCCDDEEFF5A,64'h1122334455667788,128'h0},
        '{3'd3,1'b0,1'b0,1'b0,1'b0,16'h0300,1'b0,2'd1,8'hFF,8'h00,64'h99AABBCCDDEEFF5A,64'h0,128'h0},
        '{3'd3,1'b0,1'b0,1'b1,1'b0,16'h0308,1'b0,2'd1,8'hFF,8'h00,64'h99AABBCCDDEEFF5A,64'h0,128'h0},
        '{3'd4,1'b0,1'b0,1'b0,1'b1,16'h0100,1'b1,2'd0,8'h00,8'h00,64'h0,64'h0,128'h0},
        '{3'd3,1'b1,1'b1,1'b0,1'b1,16'h0100,1'b1,2'd0,8'h00,8'h00,64'h0,64'h0,128'h0},
        '{3'd5,1'b0,1'b0,1'b1,1'b0,16'h0100,1'b1,2'd0,8'h00,8'h00,64'h0,64'h0,128'h0}
    };
    // tags per row: R3 R3 R3,R8 R4 R3 R1 R6 R7 R3 R4 | R1,R8 R1,R8 R5 R7 R1 R5 | R2 R4 R2

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_size = '0;
    logic         req_signed = 1'b0;
    logic         req_ext32 = 1'b0;
    logic         req_vec = 1'b0;
    logic         req_load = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [127:0] req_wdata = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [7:0]   mem_be;
    logic [63:0]  mem_wdata;
    logic [63:0]  mem_rdata;
    logic         done;
    logic         err;
    logic [127:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign mem_rdata = mem_addr[3] ? MEM_HI : MEM_LO;

    ldst_fmt_unit #(.AW(32)) i_ldst_fmt_unit (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_signed(req_signed), .req_ext32(req_ext32),
        .req_vec(req_vec), .req_load(req_load), .req_addr(req_addr),
        .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .done(done), .err(err), .rdata(rdata)
    );

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid  = 1'b1;
        req_size   = v.sz;
        req_signed = v.sg;
        req_ext32  = v.x3;
        req_vec    = v.ve;
        req_load   = v.ld;
        req_addr   = {16'h0, v.ad};
        req_wdata  = SRC;
    endtask

    task automatic run_vec(input vec_t v, input int stall_n, input int idx);
        int nb = 0;
        int st = stall_n;
        int guard = 0;
        logic [31:0] a [2];
        logic [7:0]  b [2];
        logic [63:0] w [2];
        logic [31:0] stall_addr = '0;
        bit seen_done = 1'b0;
        bit busy_ok = 1'b1;
        bit hold_ok = 1'b1;
        @(negedge clk);
        drive(v);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen_done && guard < 60) begin
            if (done) begin
                seen_done = 1'b1;
                mem_ready = 1'b0;
                check(req_ready == 1'b1, $sformatf("R9 row %0d ready with done", idx),
                      128'(req_ready), 128'd1);
                check(err == v.er, $sformatf("R10 row %0d err", idx), 128'(err), 128'(v.er));
            end else begin
                if (req_ready) busy_ok = 1'b0;
                if (mem_valid) begin
                    if (st > 0) begin
                        if (st == stall_n) stall_addr = mem_addr;
                        else if (mem_addr != stall_addr) hold_ok = 1'b0;
                        mem_ready = 1'b0;
                        st--;
                    end else begin
                        if (stall_n > 0 && mem_addr != stall_addr) hold_ok = 1'b0;
                        mem_ready = 1'b1;
                        if (nb < 2) begin
                            a[nb] = mem_addr; b[nb] = mem_be; w[nb] = mem_wdata;
                        end
                        nb++;
                        st = stall_n;
                    end
                end else begin
                    mem_ready = 1'b0;
                end
                @(negedge clk);
                guard++;
            end
        end
        check(seen_done, $sformatf("R9 row %0d done seen", idx), 128'(seen_done), 128'd1);
        check(busy_ok, $sformatf("R9 row %0d ready low while busy", idx),
              128'(busy_ok), 128'd1);
        check(nb == int'(v.nb), $sformatf("R7 R10 row %0d beat count", idx),
              128'(nb), 128'(v.nb));
        if (stall_n > 0)
            check(hold_ok, $sformatf("R11 row %0d address held in stall", idx),
                  128'(hold_ok), 128'd1);
        for (int k = 0; k < 2; k++) begin
            if (k < nb && k < int'(v.nb)) begin
                check(a[k] == {16'h0, v.ad} + 32'(8*k),
                      $sformatf("R7 row %0d beat %0d addr", idx, k),
                      128'(a[k]), 128'({16'h0, v.ad} + 32'(8*k)));
                check(b[k] == (k == 0 ? v.b0 : v.b1),
                      $sformatf("R1 row %0d beat %0d byte enables", idx, k),
                      128'(b[k]), 128'(k == 0 ? v.b0 : v.b1));
                if (!v.ld)
                    check(w[k] == (k == 0 ? v.w0 : v.w1),
                          $sformatf("R5 R8 row %0d beat %0d write data", idx, k),
                          128'(w[k]), 128'(k == 0 ? v.w0 : v.w1));
            end
        end
        if (v.ld && !v.er)
            check(rdata == v.rd, $sformatf("R3 R4 R6 row %0d load result", idx),
                  rdata, v.rd);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(req_ready == 1'b1, "R9 reset ready", 128'(req_ready), 128'd1);
        check(mem_valid == 1'b0, "R9 reset mem_valid", 128'(mem_valid), 128'd0);
        check(done == 1'b0 && err == 1'b0, "R9 reset done/err", 128'({done, err}), 128'd0);
        check(rdata == '0, "R9 reset rdata", rdata, 128'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(TBL[i], 0, i);
        end

        // R11 R7: 16-byte vector load with memory stalls on each beat
        run_vec(TBL[7], 2, 100);
        // R11: stalled store keeps its lanes
        run_vec(TBL[10], 3, 101);

        // R9 R10: illegal request waiting behind a legal 8-byte load
        @(negedge clk);
        drive(TBL[5]);
        @(posedge clk);
        @(negedge clk);
        drive(TBL[17]);
        mem_ready = 1'b1;
        @(negedge clk);
        check(done == 1'b1 && err == 1'b0, "R9 first done clean",
              128'({done, err}), 128'b10);
        check(req_ready == 1'b1, "R9 ready in done cycle", 128'(req_ready), 128'd1);
        check(rdata == {64'h0, MEM_LO}, "R9 result at done", rdata, {64'h0, MEM_LO});
        @(negedge clk);
        req_valid = 1'b0;
        mem_ready = 1'b0;
        check(done == 1'b1 && err == 1'b1, "R10 back-to-back illegal done+err",
              128'({done, err}), 128'b11);
        check(mem_valid == 1'b0, "R10 no beat for illegal", 128'(mem_valid), 128'd0);
        check(rdata == {64'h0, MEM_LO}, "R10 result untouched by illegal",
              rdata, {64'h0, MEM_LO});
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R9 done is one cycle",
              128'({done, req_ready}), 128'b01);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule